// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer with Shared Interrupt

The block is a bus-attached timer peripheral. It holds four independent down-counters, each either 16 or 32 bits wide, and a shared set of interrupt registers. Software talks to it through a word-addressed port with one write strobe. Reads are combinational: the read data shows the register at the current address.

Each channel has its own control register. The control register sets the enable, the count width, and a prescaler that divides the clock by 1, 16 or 256. It also selects one of three expiry behaviours: wrap to all-ones, reload from a separate background register, or stop at zero. Each background register can be rewritten while its channel runs. The new value only takes effect at the next reload.

When a channel expires, it sets its bit in the raw interrupt status. A mask register selects which raw bits reach the single interrupt output. Writing ones to the clear register drops raw bits.

Top module: `multi_timer_unit`

## Requirements
- R1: After reset every register reads zero and irq is low.
- R2: Register map. Bits [3:2] of the address pick the word. Shared group (address 0x000): 0x00 mask, 0x04 raw status, 0x08 masked status, 0x0C clear (reads zero). Channel n (n=0..3) at base 0x10+0x10·n: +0 load, +4 current value, +8 control, +C background load. The control field layout is: bit 7 enable, bit 6 periodic, bits 3:2 prescale, bit 1 wide (32-bit), bit 0 one-shot. Control bits 5:4 and 31:8 read as zero. Unmapped addresses read zero.
- R3: A write to the load register replaces the count on that edge, masked to the current width. The load register reads back the full written word. That cycle's count step and expiry event are dropped.
- R4: An enabled channel decrements once per prescaled tick. Prescale 00 ticks on every clock, 01 on every 16th clock, and 10 or 11 on every 256th clock. The divider restarts on a load write and when the enable bit is written from 0 to 1. So after a load of V with divide-by-D, the value V is visible for D cycles before V−1.
- R5: With the wide bit clear, the counter uses only the low 16 bits, and a loaded value is truncated to them.
- R6: Expiry is a tick taken while the count is zero. With periodic and one-shot both clear, expiry sets the count to all-ones of the width (0xFFFF or 0xFFFFFFFF) and sets the channel's raw bit.
- R7: With periodic set and one-shot clear, expiry copies the background value (masked to width) into the count and sets the raw bit. Background writes never change the running count.
- R8: With one-shot set (it overrides periodic), expiry sets the raw bit once. The count then holds zero with no further events until a load write or a 0-to-1 enable write.
- R9: With enable clear, the count and the divider stay frozen.
- R10: Raw bit n is set by channel n's expiry. Writing ones to the clear register clears those raw bits, and zero bits have no effect. An expiry in the same cycle as a clear of its bit leaves the bit set.
- R11: Masked status equals raw AND mask. irq is high exactly when any masked bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 12 | Byte address; bits [1:0] are ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed register, combinational |
| irq | output | 1 | Combined interrupt |

## Verification
The interesting collision is a channel expiring in the same clock edge as a write that clears that channel's raw status bit. The set has to win, or the expiry would be lost. The bench provokes this directly: it loads a periodic channel with a known count and issues the clear in the exact cycle where the count shows zero. It then expects the raw bit still set on the next cycle, and gone after a second clear. Random traffic mixes load, control and clear writes with running channels, and a cycle-by-cycle reference model judges every read and the interrupt line. This also covers load writes that coincide with an expiry.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    parameter int unsigned TMR_DW     = 32;
    parameter int unsigned TMR_PW     = 8;
    parameter int unsigned TMR_NARROW = 16;

    // Word select within a channel group
    localparam logic [1:0] SEL_LOAD   = 2'd0;
    localparam logic [1:0] SEL_VALUE  = 2'd1;
    localparam logic [1:0] SEL_CTRL   = 2'd2;
    localparam logic [1:0] SEL_BGLOAD = 2'd3;

    // Word select within the shared group
    localparam logic [1:0] SEL_MASK   = 2'd0;
    localparam logic [1:0] SEL_RAW    = 2'd1;
    localparam logic [1:0] SEL_MASKED = 2'd2;
    localparam logic [1:0] SEL_CLEAR  = 2'd3;

    // Control field positions
    localparam int unsigned CTL_EN   = 7;
    localparam int unsigned CTL_PER  = 6;
    localparam int unsigned CTL_PSHI = 3;
    localparam int unsigned CTL_PSLO = 2;
    localparam int unsigned CTL_WIDE = 1;
    localparam int unsigned CTL_ONCE = 0;
    localparam logic [7:0]  CTL_KEEP = 8'hCF;

    typedef struct packed {
        logic [TMR_DW-1:0] load;
        logic [TMR_DW-1:0] count;
        logic [TMR_DW-1:0] bgload;
        logic [7:0]        ctrl;
        logic [TMR_PW-1:0] pre;
        logic              stopped;
    } chan_state_t;
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [TMR_DW-1:0] wdata_i,
    output logic [TMR_DW-1:0] load_o,
    output logic [TMR_DW-1:0] count_o,
    output logic [7:0]        ctrl_o,
    output logic [TMR_DW-1:0] bgload_o,
    output logic              evt_o
);
    localparam logic [TMR_DW-1:0] NARROW_MASK =
        {{(TMR_DW-TMR_NARROW){1'b0}}, {TMR_NARROW{1'b1}}};

    chan_state_t       st_d, st_q;
    logic [TMR_DW-1:0] width_mask;
    logic [TMR_DW-1:0] cnt_m;
    logic [TMR_PW-1:0] pre_last;
    logic              running;
    logic              tick;
    logic              evt_d;

    always_comb begin
        st_d  = st_q;
        evt_d = 1'b0;

        width_mask = st_q.ctrl[CTL_WIDE] ? '1 : NARROW_MASK;
        case (st_q.ctrl[CTL_PSHI:CTL_PSLO])
            2'b00:   pre_last = '0;
            2'b01:   pre_last = TMR_PW'(15);
            default: pre_last = TMR_PW'(255);
        endcase

        cnt_m   = st_q.count & width_mask;
        running = st_q.ctrl[CTL_EN] && !st_q.stopped;
        tick    = running && (st_q.pre == pre_last);

        if (running) begin
            st_d.pre = tick ? '0 : st_q.pre + 1'b1;
        end

        if (tick) begin
            if (cnt_m == '0) begin
                evt_d = 1'b1;
                if (st_q.ctrl[CTL_ONCE]) begin
                    st_d.stopped = 1'b1;
                    st_d.count   = '0;
                end else if (st_q.ctrl[CTL_PER]) begin
                    st_d.count = st_q.bgload & width_mask;
                end else begin
                    st_d.count = width_mask;
                end
            end else begin
                st_d.count = cnt_m - 1'b1;
            end
        end

        if (wr_en_i) begin
            case (wr_sel_i)
                SEL_LOAD: begin
                    st_d.load    = wdata_i;
                    st_d.count   = wdata_i & width_mask;
                    st_d.pre     = '0;
                    st_d.stopped = 1'b0;
                    evt_d        = 1'b0;
                end
                SEL_CTRL: begin
                    st_d.ctrl = wdata_i[7:0] & CTL_KEEP;
                    if (wdata_i[CTL_EN] && !st_q.ctrl[CTL_EN]) begin
                        st_d.pre     = '0;
                        st_d.stopped = 1'b0;
                    end
                end
                SEL_BGLOAD: st_d.bgload = wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_o   = st_q.load;
    assign count_o  = st_q.count;
    assign ctrl_o   = st_q.ctrl;
    assign bgload_o = st_q.bgload;
    assign evt_o    = evt_d;

    // R9: disabled channel keeps count and divider
    assert_frozen_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl[CTL_EN] && !wr_en_i) |=> ($stable(st_q.count) && $stable(st_q.pre)));

    // R8: a finished one-shot stays at zero
    assert_oneshot_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stopped && !wr_en_i) |=> (st_q.count == '0 && st_q.stopped));

    // R4: a tick on a nonzero count steps down by one
    assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_m != '0 && !wr_en_i) |=> (st_q.count == $past(cnt_m) - 1'b1));

    // R7: periodic expiry reloads the background value
    assert_periodic_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o && st_q.ctrl[CTL_PER] && !st_q.ctrl[CTL_ONCE])
        |=> (st_q.count == ($past(st_q.bgload) & $past(width_mask))));

    // R6: free-running expiry wraps to all-ones of the width
    assert_free_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o && !st_q.ctrl[CTL_PER] && !st_q.ctrl[CTL_ONCE])
        |=> (st_q.count == $past(width_mask)));
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
    import tmr_pkg::*;
#(
    parameter int unsigned NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [NUM_CH-1:0] wdata_i,
    input  logic [NUM_CH-1:0] evt_i,
    output logic [NUM_CH-1:0] mask_o,
    output logic [NUM_CH-1:0] raw_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] mask;
        logic [NUM_CH-1:0] raw;
    } irq_state_t;

    irq_state_t        st_d, st_q;
    logic [NUM_CH-1:0] clr_bits;

    always_comb begin
        st_d     = st_q;
        clr_bits = (wr_en_i && wr_sel_i == SEL_CLEAR) ? wdata_i : '0;
        if (wr_en_i && wr_sel_i == SEL_MASK) begin
            st_d.mask = wdata_i;
        end
        st_d.raw = (st_q.raw & ~clr_bits) | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o = st_q.mask;
    assign raw_o  = st_q.raw;
    assign irq_o  = |(st_q.raw & st_q.mask);

    // R10: an expiry always lands in raw status, even against a clear
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((raw_o & $past(evt_i)) == $past(evt_i)));

    // R10: cleared bits without a concurrent expiry drop
    assert_clear_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_bits) |=> ((raw_o & $past(clr_bits & ~evt_i)) == '0));

    // R11: mask changes only through its own write
    assert_mask_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && wr_sel_i == SEL_MASK) |=> $stable(mask_o));
endmodule

// File: rtl/multi_timer_unit.sv
module multi_timer_unit
    import tmr_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [TMR_DW-1:0] wdata,
    output logic [TMR_DW-1:0] rdata,
    output logic              irq
);
    localparam int unsigned GRP_W = ADDR_W - 4;

    logic [GRP_W-1:0]  grp;
    logic [1:0]        sel;
    logic [NUM_CH-1:0] evt;
    logic [NUM_CH-1:0] mask;
    logic [NUM_CH-1:0] raw;
    logic [TMR_DW-1:0] load_a   [NUM_CH];
    logic [TMR_DW-1:0] count_a  [NUM_CH];
    logic [TMR_DW-1:0] bgload_a [NUM_CH];
    logic [7:0]        ctrl_a   [NUM_CH];
    logic              unused_addr_bits;

    assign grp = addr[ADDR_W-1:4];
    assign sel = addr[3:2];
    assign unused_addr_bits = ^addr[1:0];

    genvar ch;
    generate
        for (ch = 0; ch < NUM_CH; ch++) begin : g_chan
            logic chan_we;
            assign chan_we = wr_en && (grp == GRP_W'(ch + 1));
            tmr_channel u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en_i  (chan_we),
                .wr_sel_i (sel),
                .wdata_i  (wdata),
                .load_o   (load_a[ch]),
                .count_o  (count_a[ch]),
                .ctrl_o   (ctrl_a[ch]),
                .bgload_o (bgload_a[ch]),
                .evt_o    (evt[ch])
            );
        end
    endgenerate

    tmr_irq_ctrl #(.NUM_CH(NUM_CH)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en && (grp == '0)),
        .wr_sel_i (sel),
        .wdata_i  (wdata[NUM_CH-1:0]),
        .evt_i    (evt),
        .mask_o   (mask),
        .raw_o    (raw),
        .irq_o    (irq)
    );

    always_comb begin
        rdata = '0;
        if (grp == '0) begin
            case (sel)
                SEL_MASK:   rdata = TMR_DW'(mask);
                SEL_RAW:    rdata = TMR_DW'(raw);
                SEL_MASKED: rdata = TMR_DW'(raw & mask);
                default:    rdata = '0;
            endcase
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (grp == GRP_W'(c + 1)) begin
                case (sel)
                    SEL_LOAD:   rdata = load_a[c];
                    SEL_VALUE:  rdata = count_a[c];
                    SEL_CTRL:   rdata = TMR_DW'(ctrl_a[c]);
                    default:    rdata = bgload_a[c];
                endcase
            end
        end
    end

    // R11: the interrupt line agrees with the masked status readout
    assert_irq_matches_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (grp == '0 && sel == SEL_MASKED) |-> (irq == (rdata != '0)));
endmodule

// File: tb/multi_timer_unit_tb.sv
module multi_timer_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] m_ld [4];
    logic [31:0] m_cnt[4];
    logic [31:0] m_bg [4];
    logic [7:0]  m_ctl[4];
    logic [7:0]  m_pre[4];
    logic        m_stop[4];
    logic [3:0]  m_mask;
    logic [3:0]  m_raw;

    always #5 clk = ~clk;

    multi_timer_unit dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    function automatic logic [11:0] cha(input int n, input int off);
        return 12'(16 + 16 * n + off);
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a);
        int g = int'(a[11:4]);
        int s = int'(a[3:2]);
        if (g == 0) begin
            case (s)
                0: return {28'b0, m_mask};
                1: return {28'b0, m_raw};
                2: return {28'b0, m_raw & m_mask};
                default: return 32'b0;
            endcase
        end
        if (g >= 1 && g <= 4) begin
            case (s)
                0: return m_ld[g-1];
                1: return m_cnt[g-1];
                2: return {24'b0, m_ctl[g-1]};
                default: return m_bg[g-1];
            endcase
        end
        return 32'b0;
    endfunction

    function automatic string tag_of(input logic [11:0] a);
        int g = int'(a[11:4]);
        int s = int'(a[3:2]);
        if (g == 0) return (s == 1) ? "R10" : (s == 2) ? "R11" : "R2";
        if (g > 4) return "R2";
        case (s)
            0: return "R3";
            1: return "R4";
            2: return "R2";
            default: return "R7";
        endcase
    endfunction

    task automatic check_eq(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_ld[i] = '0; m_cnt[i] = '0; m_bg[i] = '0;
            m_ctl[i] = '0; m_pre[i] = '0; m_stop[i] = 1'b0;
        end
        m_mask = '0;
        m_raw  = '0;
    endtask

    // One clock of the reference behaviour, derived from R3..R11
    task automatic model_step(input logic we, input logic [11:0] a, input logic [31:0] d);
        logic [3:0] evt = '0;
        logic [3:0] clr = '0;
        int g = int'(a[11:4]);
        int s = int'(a[3:2]);
        for (int i = 0; i < 4; i++) begin
            logic [31:0] wm, cm, nc, nld, nbg;
            logic [7:0]  pl, np, nctl;
            logic        run, tk, ns, ev;
            wm  = m_ctl[i][1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
            pl  = (m_ctl[i][3:2] == 2'b00) ? 8'd0 : (m_ctl[i][3:2] == 2'b01) ? 8'd15 : 8'd255;
            cm  = m_cnt[i] & wm;
            run = m_ctl[i][7] && !m_stop[i];
            tk  = run && (m_pre[i] == pl);
            nc = m_cnt[i]; np = m_pre[i]; ns = m_stop[i]; ev = 1'b0;
            nld = m_ld[i]; nbg = m_bg[i]; nctl = m_ctl[i];
            if (run) np = tk ? 8'd0 : m_pre[i] + 8'd1;
            if (tk) begin
                if (cm == 0) begin
                    ev = 1'b1;
                    if (m_ctl[i][0]) begin ns = 1'b1; nc = 0; end
                    else if (m_ctl[i][6]) nc = m_bg[i] & wm;
                    else nc = wm;
                end else nc = cm - 1;
            end
            if (we && g == i + 1) begin
                if (s == 0) begin nld = d; nc = d & wm; np = 0; ns = 1'b0; ev = 1'b0; end
                if (s == 2) begin
                    nctl = d[7:0] & 8'hCF;
                    if (d[7] && !m_ctl[i][7]) begin np = 0; ns = 1'b0; end
                end
                if (s == 3) nbg = d;
            end
            evt[i] = ev;
            m_cnt[i] = nc; m_pre[i] = np; m_stop[i] = ns;
            m_ld[i] = nld; m_bg[i] = nbg; m_ctl[i] = nctl;
        end
        if (we && g == 0 && s == 0) m_mask = d[3:0];
        if (we && g == 0 && s == 3) clr = d[3:0];
        m_raw = (m_raw & ~clr) | evt;
    endtask

    task automatic cycle(input logic we, input logic [11:0] a, input logic [31:0] d,
                         input bit lit, input logic [31:0] lmask, input logic [31:0] lval,
                         input string ltag);
        @(negedge clk);
        wr_en = we; addr = a; wdata = d;
        #1;
        check_eq(rdata, model_read(a), tag_of(a));
        check_eq({31'b0, irq}, {31'b0, |(m_raw & m_mask)}, "R11");
        if (lit) check_eq(rdata & lmask, lval, ltag);
        model_step(we, a, d);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        cycle(1'b1, a, d, 1'b0, 32'h0, 32'h0, "");
    endtask
    task automatic rd(input logic [11:0] a);
        cycle(1'b0, a, 32'h0, 1'b0, 32'h0, 32'h0, "");
    endtask
    task automatic rd_lit(input logic [11:0] a, input logic [31:0] m, input logic [31:0] v,
                          input string t);
        cycle(1'b0, a, 32'h0, 1'b1, m, v, t);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: everything zero after reset
        for (int g = 0; g < 5; g++)
            for (int s = 0; s < 4; s++)
                rd_lit(12'(16 * g + 4 * s), 32'hFFFF_FFFF, 32'h0, "R1");

        // R2: control readback drops unused bits; clear reads zero
        wr(cha(2, 8), 32'hFFFF_FFFF);
        rd_lit(cha(2, 8), 32'hFFFF_FFFF, 32'h0000_00CF, "R2");
        rd_lit(12'h00C, 32'hFFFF_FFFF, 32'h0, "R2");
        rd_lit(12'h0F0, 32'hFFFF_FFFF, 32'h0, "R2");

        // R3 / R4: divide-by-1 countdown
        wr(cha(1, 8), 32'h82);
        wr(cha(1, 0), 32'd10);
        rd_lit(cha(1, 4), 32'hFFFF_FFFF, 32'd10, "R3");
        rd(cha(1, 4)); rd(cha(1, 4));
        rd_lit(cha(1, 4), 32'hFFFF_FFFF, 32'd7, "R4");

        // R4: divide-by-16 holds the loaded value for 16 cycles
        wr(cha(2, 8), 32'h86);
        wr(cha(2, 0), 32'd5);
        repeat (15) rd(cha(2, 4));
        rd_lit(cha(2, 4), 32'hFFFF_FFFF, 32'd5, "R4");
        rd_lit(cha(2, 4), 32'hFFFF_FFFF, 32'd4, "R4");

        // R5 / R6: 16-bit truncation and wrap, then 32-bit wrap
        wr(12'h00C, 32'hF);
        wr(cha(3, 8), 32'h80);
        wr(cha(3, 0), 32'h0001_2345);
        rd_lit(cha(3, 4), 32'hFFFF_FFFF, 32'h2345, "R5");
        wr(cha(3, 0), 32'd1);
        rd(cha(3, 4)); rd(cha(3, 4));
        rd_lit(cha(3, 4), 32'hFFFF_FFFF, 32'h0000_FFFF, "R5");
        rd_lit(12'h004, 32'h8, 32'h8, "R6");
        wr(cha(3, 8), 32'h82);
        wr(cha(3, 0), 32'd0);
        rd(cha(3, 4));
        rd_lit(cha(3, 4), 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6");

        // R7: periodic reload; background write does not disturb the count
        wr(cha(0, 8), 32'hC2);
        wr(cha(0, 12), 32'd3);
        wr(cha(0, 0), 32'd1);
        rd(cha(0, 4)); rd(cha(0, 4));
        rd_lit(cha(0, 4), 32'hFFFF_FFFF, 32'd3, "R7");
        wr(cha(0, 12), 32'd7);
        rd_lit(cha(0, 4), 32'hFFFF_FFFF, 32'd1, "R7");
        rd(cha(0, 4));
        rd_lit(cha(0, 4), 32'hFFFF_FFFF, 32'd7, "R7");

        // R8: one-shot fires once and holds zero
        wr(cha(1, 8), 32'h83);
        wr(12'h00C, 32'hF);
        wr(cha(1, 0), 32'd2);
        rd(cha(1, 4)); rd(cha(1, 4)); rd(cha(1, 4));
        rd_lit(12'h004, 32'h2, 32'h2, "R8");
        wr(12'h00C, 32'h2);
        repeat (20) rd(cha(1, 4));
        rd_lit(cha(1, 4), 32'hFFFF_FFFF, 32'd0, "R8");
        rd_lit(12'h004, 32'h2, 32'h0, "R8");

        // R9: disabled channel is frozen
        wr(cha(1, 8), 32'h02);
        wr(cha(1, 0), 32'd9);
        repeat (10) rd(cha(1, 4));
        rd_lit(cha(1, 4), 32'hFFFF_FFFF, 32'd9, "R9");

        // R10: expiry and clear of the same bit in one cycle
        wr(cha(0, 12), 32'd5);
        wr(12'h00C, 32'hF);
        wr(cha(0, 0), 32'd2);
        rd(cha(0, 4)); rd(cha(0, 4));
        wr(12'h00C, 32'h1);
        rd_lit(12'h004, 32'h1, 32'h1, "R10");
        wr(12'h00C, 32'h1);
        rd_lit(12'h004, 32'h1, 32'h0, "R10");

        // R11: masked status and irq
        wr(12'h000, 32'h1);
        rd(12'h008); rd(12'h008);
        rd_lit(12'h008, 32'hFFFF_FFFF, 32'h1, "R11");
        wr(12'h000, 32'h0);
        rd_lit(12'h008, 32'hFFFF_FFFF, 32'h0, "R11");

        // Random traffic judged by the reference model
        for (int k = 0; k < 3000; k++) begin
            int r = int'($urandom % 100);
            int n = int'($urandom % 4);
            logic [11:0] ra = 12'(16 * ($urandom % 6) + 4 * ($urandom % 4));
            if (r < 8) wr(cha(n, 0), $urandom % 48);
            else if (r < 12) wr(cha(n, 12), $urandom % 40);
            else if (r < 16) begin
                logic [31:0] c = $urandom;
                c[7] = ($urandom % 4) != 0;
                if ($urandom % 6 != 0) c[3:2] = 2'b00;
                wr(cha(n, 8), c);
            end
            else if (r < 20) wr(12'h000, $urandom);
            else if (r < 27) wr(12'h00C, $urandom);
            else rd(ra);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule